// File: doc/BRIEF.md
# Serial Audio Slot Transmitter

This block is a single transmit lane of a frame-synchronous serial audio port. Software or a DMA engine writes a parallel word into a one-entry holding register. At each slot boundary the lane moves that word into its shift stage and sends it one bit per bit-clock strobe on a shared serial data pin. The bit clock and the frame sync come from outside the block. Configuration inputs set the word length, the slot length, the bit order, the placement of a short word inside a longer slot, and the padding policy.

An enable input controls the lane. The lane begins driving only at a frame sync, and it stops only at a slot boundary, so a word that has already started is always sent in full. A pulse of enable low in the middle of a slot still ends the lane at the next boundary, and the pin then stays high-impedance until the next frame sync. The data pin is shared with a receiver. The block reports whether it drives the pin, and whether the pin is handed to the receiver. A holding-empty flag tells the writer when to supply the next word. A sticky underrun flag records any slot that had no fresh word.

Top module: `audio_slot_tx`

## Requirements
- R1: After reset `sdo_oe_o`=0, `sdo_o`=0, `hold_empty_o`=1, `underrun_o`=0 and `rx_sel_o`=0.
- R2: With `lsb_first_i`=0, data bit j of a slot carries word bit `word_len-1-j`. With `lsb_first_i`=1 it carries word bit j. Bits of the holding word at or above `word_len` never appear on the pin.
- R3: With `right_align_i`=0 the word occupies slot bits 0..`word_len-1`. The remaining slot bits are 0 when `zero_pad_i`=1. When `zero_pad_i`=0 they repeat the last data bit sent.
- R4: With `right_align_i`=1 the first `slot_len-word_len` slot bits are 0, and the word fills the end of the slot.
- R5: An idle lane starts driving only on a bit strobe that carries `fsync_i`=1 while `tx_en_i`=1. Enabling it in the middle of a frame has no effect on the pin until that strobe.
- R6: When `tx_en_i` falls in the middle of a slot, the remaining bits of the current word are still sent with `sdo_oe_o`=1. The pin is released at the next slot start.
- R7: While the lane is disabled a write is accepted (`hold_empty_o` falls), but no slot start moves the word out of the holding register.
- R8: `hold_empty_o` clears on the clock after a write. It sets on the slot-start strobe that moves the held word into the shift stage.
- R9: `sdo_oe_o` is 1 only while the lane is active, and `sdo_o` is 0 whenever `sdo_oe_o` is 0. `rx_sel_o` is 1 exactly when the lane is inactive and `rx_en_i`=1. `tx_en_i` and `rx_en_i` must never both be 1.
- R10: If `tx_en_i` drops and rises again within a slot, the lane stops at the next slot start and stays undriven until the next frame sync.
- R11: At a slot start of an active lane with an empty holding register, the previous word is sent again and `underrun_o` sets and stays set until reset.
- R12: A slot start happens on every frame-sync strobe and after every `slot_len` strobes. Outputs change only on bit strobes: each bit appears on the clock after its strobe and is held until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bclk_en_i | input | 1 | One-cycle strobe per serial bit |
| fsync_i | input | 1 | Frame sync, qualified by `bclk_en_i`; marks bit 0 of a frame |
| word_len_i | input | LEN_W | Data word length in bits (1..DATA_W, not above slot length) |
| slot_len_i | input | LEN_W | Slot length in bits (1..SLOT_MAX) |
| lsb_first_i | input | 1 | 0: most significant bit first, 1: least significant bit first |
| right_align_i | input | 1 | 0: word at start of slot, 1: word at end of slot |
| zero_pad_i | input | 1 | Trailing pad for left-aligned words: 1 zeros, 0 repeat last bit |
| tx_en_i | input | 1 | Lane enable |
| rx_en_i | input | 1 | Receiver enable for the shared pin |
| wr_i | input | 1 | Holding register write strobe |
| wr_data_i | input | DATA_W | Word to write, right-justified |
| hold_empty_o | output | 1 | Holding register empty |
| underrun_o | output | 1 | Sticky: a slot started with no fresh word |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for the shared pin |
| rx_sel_o | output | 1 | Shared pin is routed to the receiver |

## Verification
The main sweep covers every word length from 1 to 8 with every legal slot length up to 12. Each pair runs under all eight combinations of bit order, alignment and pad policy. Every bit of two consecutive slots is compared with a value computed arithmetically, so the sweep separates mirrored bit order, an off-by-one pad width, leakage of unused high bits, and a swapped pad policy. The second slot starts without a frame sync, which exposes wrong wrap counting. Directed sequences cover writes while disabled, enabling mid-frame, a short enable glitch, disabling mid-word with the receiver waiting, and underrun resend. Each of these separates boundary-timed control from control that acts immediately.

// File: rtl/sat_pkg.sv
package sat_pkg;
  typedef enum logic {ORD_MSB_FIRST = 1'b0, ORD_LSB_FIRST = 1'b1} bit_order_e;
  typedef enum logic {ALN_LEFT = 1'b0, ALN_RIGHT = 1'b1} slot_align_e;
endpackage

// File: rtl/sat_slot_ctr.sv
module sat_slot_ctr #(
  parameter int LEN_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bclk_en_i,
  input  logic             fsync_i,
  input  logic [LEN_W-1:0] slot_len_i,
  output logic [LEN_W-1:0] idx_o,
  output logic             slot_start_o
);
  logic [LEN_W-1:0] nxt_q;
  logic [LEN_W:0]   inc;

  always_comb begin
    idx_o        = fsync_i ? '0 : nxt_q;
    inc          = {1'b0, idx_o} + 1'b1;
    slot_start_o = bclk_en_i && (idx_o == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) nxt_q <= '0;
    else if (bclk_en_i) nxt_q <= (inc >= {1'b0, slot_len_i}) ? '0 : inc[LEN_W-1:0];
  end
endmodule

// File: rtl/sat_hold.sv
module sat_hold #(
  parameter int DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              load_i,
  output logic [DATA_W-1:0] hold_o,
  output logic              empty_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_o  <= '0;
      empty_o <= 1'b1;
    end else begin
      if (wr_i) hold_o <= wr_data_i;
      // a write in the load cycle keeps the new word pending
      if (wr_i) empty_o <= 1'b0;
      else if (load_i) empty_o <= 1'b1;
    end
  end

  AST_EMPTY_SET_ON_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(empty_o) |-> $past(load_i)); // R8
  AST_EMPTY_CLR_ON_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(empty_o) |-> $past(wr_i)); // R8
endmodule

// File: rtl/sat_bit_sel.sv
module sat_bit_sel
  import sat_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int LEN_W  = 6
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic [LEN_W-1:0]  idx_i,
  input  logic [LEN_W-1:0]  wlen_i,
  input  logic [LEN_W-1:0]  slen_i,
  input  logic              lsb_first_i,
  input  logic              right_align_i,
  input  logic              zero_pad_i,
  output logic              bit_o
);
  bit_order_e        order;
  slot_align_e       align;
  logic [LEN_W-1:0]  pad_len, j, pos, last_pos;
  logic              use_pad, pad_bit, last_bit;
  logic [DATA_W-1:0] sh_data, sh_last;

  always_comb begin
    order    = bit_order_e'(lsb_first_i);
    align    = slot_align_e'(right_align_i);
    pad_len  = slen_i - wlen_i;
    last_pos = (order == ORD_LSB_FIRST) ? wlen_i - 1'b1 : '0;
    sh_last  = word_i >> last_pos;
    last_bit = sh_last[0];
    use_pad  = 1'b0;
    pad_bit  = 1'b0;
    j        = '0;
    if (align == ALN_RIGHT) begin
      if (idx_i < pad_len) use_pad = 1'b1;
      else j = idx_i - pad_len;
    end else begin
      if (idx_i >= wlen_i) begin
        use_pad = 1'b1;
        pad_bit = zero_pad_i ? 1'b0 : last_bit;
      end else begin
        j = idx_i;
      end
    end
    pos     = (order == ORD_LSB_FIRST) ? j : wlen_i - 1'b1 - j;
    sh_data = word_i >> pos;
    bit_o   = use_pad ? pad_bit : sh_data[0];
  end
endmodule

// File: rtl/audio_slot_tx.sv
module audio_slot_tx #(
  parameter int DATA_W   = 24,
  parameter int SLOT_MAX = 32,
  localparam int LEN_W   = $clog2(SLOT_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bclk_en_i,
  input  logic              fsync_i,
  input  logic [LEN_W-1:0]  word_len_i,
  input  logic [LEN_W-1:0]  slot_len_i,
  input  logic              lsb_first_i,
  input  logic              right_align_i,
  input  logic              zero_pad_i,
  input  logic              tx_en_i,
  input  logic              rx_en_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              hold_empty_o,
  output logic              underrun_o,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              rx_sel_o
);
  logic [LEN_W-1:0]  idx;
  logic              slot_start;
  logic [DATA_W-1:0] hold_word, shreg_q, cur_word;
  logic              active_q, stop_q;
  logic              go, load, urun_set, act_nxt, tx_bit;

  sat_slot_ctr #(.LEN_W(LEN_W)) u_ctr (
    .clk_i, .rst_ni, .bclk_en_i, .fsync_i,
    .slot_len_i,
    .idx_o        (idx),
    .slot_start_o (slot_start)
  );

  sat_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i, .rst_ni, .wr_i, .wr_data_i,
    .load_i  (load),
    .hold_o  (hold_word),
    .empty_o (hold_empty_o)
  );

  // lane continues at a slot start unless a disable was seen during the slot
  always_comb begin
    go       = slot_start && tx_en_i && (fsync_i || (active_q && !stop_q));
    load     = go && !hold_empty_o;
    urun_set = go && hold_empty_o;
    act_nxt  = slot_start ? go : active_q;
    cur_word = load ? hold_word : shreg_q;
  end

  sat_bit_sel #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_sel (
    .word_i        (cur_word),
    .idx_i         (idx),
    .wlen_i        (word_len_i),
    .slen_i        (slot_len_i),
    .lsb_first_i,
    .right_align_i,
    .zero_pad_i,
    .bit_o         (tx_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      stop_q     <= 1'b0;
      shreg_q    <= '0;
      underrun_o <= 1'b0;
      sdo_o      <= 1'b0;
    end else begin
      if (active_q && !tx_en_i) stop_q <= 1'b1;
      if (bclk_en_i) begin
        if (slot_start) begin
          active_q <= go;
          stop_q   <= 1'b0;
          if (load) shreg_q <= hold_word;
          if (urun_set) underrun_o <= 1'b1;
        end
        sdo_o <= act_nxt ? tx_bit : 1'b0;
      end
    end
  end

  assign sdo_oe_o = active_q;
  assign rx_sel_o = !active_q && rx_en_i;

  AST_OE_RISE_AT_FSYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdo_oe_o) |-> $past(bclk_en_i && fsync_i)); // R5
  AST_OE_FALL_AT_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sdo_oe_o) |-> $past(slot_start)); // R6
  AST_UNDERRUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |=> underrun_o); // R11
  AST_SDO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bclk_en_i |=> $stable(sdo_o)); // R12
  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdo_oe_o |-> !sdo_o); // R9
  AST_NO_SHARED_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_en_i && rx_en_i)); // R9
endmodule

// File: tb/audio_slot_tx_bench.sv
module audio_slot_tx_bench;
  localparam int DW = 8;
  localparam int SM = 12;
  localparam int LW = $clog2(SM + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bclk_en = 1'b0, fsync = 1'b0;
  logic [LW-1:0] wlen = 4, slen = 6;
  logic          lsb = 1'b0, ralign = 1'b0, zpad = 1'b0;
  logic          tx_en = 1'b0, rx_en = 1'b0, wr = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic          empty, urun, sdo, oe, rx_sel;
  int            n_chk = 0, n_fail = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  audio_slot_tx #(.DATA_W(DW), .SLOT_MAX(SM)) u_audio_slot_tx (
    .clk_i(clk), .rst_ni(rst_n), .bclk_en_i(bclk_en), .fsync_i(fsync),
    .word_len_i(wlen), .slot_len_i(slen), .lsb_first_i(lsb),
    .right_align_i(ralign), .zero_pad_i(zpad), .tx_en_i(tx_en),
    .rx_en_i(rx_en), .wr_i(wr), .wr_data_i(wdata),
    .hold_empty_o(empty), .underrun_o(urun), .sdo_o(sdo),
    .sdo_oe_o(oe), .rx_sel_o(rx_sel)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (wl=%0d sl=%0d lsb=%0b ra=%0b zp=%0b)",
               req, act, exp, wlen, slen, lsb, ralign, zpad);
    end
  endtask

  function automatic logic exp_bit(input logic [DW-1:0] w, input int k);
    int pad = int'(slen) - int'(wlen);
    int j;
    if (ralign) begin
      if (k < pad) return 1'b0;
      j = k - pad;
    end else begin
      if (k >= int'(wlen)) return zpad ? 1'b0 : (lsb ? w[wlen-1] : w[0]);
      j = k;
    end
    return lsb ? w[j] : w[int'(wlen) - 1 - j];
  endfunction

  task automatic tick(input logic fs);
    bclk_en = 1'b1; fsync = fs;
    @(negedge clk);
    bclk_en = 1'b0; fsync = 1'b0;
    @(negedge clk);
  endtask

  task automatic write(input logic [DW-1:0] d);
    wr = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  function automatic string tag_of(input int k);
    if (ralign) return "R4";
    return (k >= int'(wlen)) ? "R3" : "R2";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] wc, wd, we;
    wc = 8'hFD; wd = 8'h36; we = 8'h0A;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 oe", oe, 0); chk("R1 sdo", sdo, 0); chk("R1 empty", empty, 1);
    chk("R1 underrun", urun, 0); chk("R1 rx_sel", rx_sel, 0);

    // R7: written word stays held while disabled
    write(wc);
    chk("R8 empty after write", empty, 0);
    for (int i = 0; i < 12; i++) begin
      tick(i % 6 == 0);
      chk("R7 oe while disabled", oe, 0);
      chk("R7 word stays held", empty, 0);
    end
    // R5: enabling mid-frame does not drive the pin
    tx_en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      tick(1'b0);
      chk("R5 no drive before fsync", oe, 0);
    end
    for (int k = 0; k < 6; k++) begin
      tick(k == 0);
      chk("R5 drive after fsync", oe, 1);
      chk(tag_of(k), sdo, exp_bit(wc, k));
      if (k == 0) chk("R8 empty after load", empty, 1);
    end
    // R11: no fresh word, previous word resent
    for (int k = 0; k < 6; k++) begin
      tick(1'b0);
      chk("R11 resend", sdo, exp_bit(wc, k));
      if (k == 0) chk("R11 underrun set", urun, 1);
    end
    write(wd);
    for (int k = 0; k < 6; k++) begin
      tick(1'b0);
      chk("R11 new word after underrun", sdo, exp_bit(wd, k));
    end
    chk("R11 underrun sticky", urun, 1);
    // R10: enable glitch inside a slot
    write(we);
    for (int k = 0; k < 6; k++) begin
      if (k == 2) tx_en = 1'b0;
      if (k == 3) tx_en = 1'b1;
      tick(1'b0);
      chk("R6 word completes", oe, 1);
      chk("R6 word bits", sdo, exp_bit(we, k));
    end
    for (int k = 0; k < 6; k++) begin
      tick(1'b0);
      chk("R10 stays undriven", oe, 0);
    end
    tick(1'b1);
    chk("R10 restart at fsync", oe, 1);
    chk("R10 restart bit", sdo, exp_bit(we, 0));
    // R6/R9: disable mid-word with receiver waiting
    tick(1'b0);
    tx_en = 1'b0; rx_en = 1'b1;
    for (int k = 2; k < 6; k++) begin
      tick(1'b0);
      chk("R6 oe until slot end", oe, 1);
      chk("R9 rx not selected while active", rx_sel, 0);
      chk("R6 tail bits", sdo, exp_bit(we, k));
    end
    tick(1'b0);
    chk("R6 released at slot start", oe, 0);
    chk("R9 rx selected", rx_sel, 1);
    chk("R9 sdo low when idle", sdo, 0);
    rx_en = 1'b0;
    @(negedge clk);
    chk("R9 both off", rx_sel, 0);

    // sweep over all formats
    for (int wl = 1; wl <= DW; wl++) begin
      for (int sl = wl; sl <= SM; sl++) begin
        for (int m = 0; m < 8; m++) begin
          logic [DW-1:0] wa, wb;
          wlen = LW'(wl); slen = LW'(sl);
          lsb = m[0]; ralign = m[1]; zpad = m[2];
          wa = DW'(8'hA5 ^ (wl * 29 + sl * 7 + m));
          wb = ~wa ^ DW'(m);
          write(wa);
          chk("R8 empty cleared", empty, 0);
          tx_en = 1'b1;
          for (int k = 0; k < sl; k++) begin
            tick(k == 0);
            chk(tag_of(k), sdo, exp_bit(wa, k));
            if (k == 0) chk("R8 loaded", empty, 1);
            if (k == 0) write(wb);
          end
          for (int k = 0; k < sl; k++) begin
            tick(1'b0);
            if (k == 0) chk("R12 wrap oe", oe, 1);
            chk(k == 0 ? "R12" : tag_of(k), sdo, exp_bit(wb, k));
          end
          tx_en = 1'b0;
          tick(1'b0);
          chk("R6 released", oe, 0);
        end
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule